// File: doc/BRIEF.md
# Chainable Event Counter Bank

The block holds a parameterised set of 32-bit event counters and one free-running cycle counter behind a flat write/read register port. Software sets a global run bit and per-counter enables, gives each counter a 16-bit event type, preloads counter values and raises software-increment strobes as a bitmask. Hardware event sources arrive as one pulse input per counter. Each counter wraps at 32 bits and raises a sticky overflow flag. The flags are readable and also driven out as a status vector.

Counters form even/odd pairs. A pair acts as one 64-bit counter while the odd member holds the chain event type and is enabled. In that mode the even counter is the low half, its carry advances the odd counter, and only the odd index can flag overflow. The chain mode is recomputed every cycle from the live enable and type registers. When the mode changes, the pair pauses for one cycle before it counts in the new mode. The parameter N_CNT must be even and below 31.

Top module: `evc_bank`

## Requirements
- R1: After reset every readable register reads zero and `ovf_o` is zero.
- R2: While the global run bit (bit 0 of the control register at 0x00) is clear, no event counter and no cycle counter advances, whatever software-increment or hardware pulse arrives.
- R3: A write of mask M to 0x05 (software increment) first drops every bit whose enable is clear. Enables are set by writing ones to 0x01 and cleared by writing ones to 0x02; both addresses read the enable mask.
- R4: A counter advances on a software increment only when its event type reads 0x0000. Type registers sit at 0x80+i (low 16 bits) and counters at 0x40+i.
- R5: A counter that is not the low half of a chained pair wraps from 0xFFFFFFFF to 0 and sets overflow bit i.
- R6: Pair (2k, 2k+1) is chained exactly when counter 2k+1 has type 0x001E and is enabled. A wrap of counter 2k then advances counter 2k+1 by one.
- R7: In a chained pair, a wrap of the even counter never sets its overflow bit. Overflow bit 2k+1 is set only when counter 2k+1 itself wraps.
- R8: In the first cycle after a pair's chain mode changes, neither counter of the pair advances.
- R9: A pulse on `evt_i[i]` advances counter i by one when the run bit and its enable are set. In a chained pair a pulse on the even input is a 64-bit increment and a pulse on the odd input is ignored.
- R10: Writing bit 1 of the control register clears every event counter and leaves the cycle counter unchanged.
- R11: The cycle counter (read/write at 0x06) advances every clock while the run bit and enable bit 31 are set. It wraps to 0 and sets overflow bit 31, and writing bit 2 of the control register clears it.
- R12: Software-increment bit 31 and all mask bits at N_CNT and above have no effect. Enable and overflow bits at N_CNT..30 always read 0.
- R13: Overflow bits are sticky. Writing ones to 0x04 clears them and writing ones to 0x03 sets them. A hardware overflow and a clear of the same bit in the same cycle leaves the bit set.
- R14: Writing 0x40+i loads counter i and takes priority over a same-cycle increment. The event-counter reset takes priority over increments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Write address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 8 | Read address (combinational read) |
| rd_data_o | output | 32 | Read data |
| evt_i | input | N_CNT | Hardware event pulses, one per counter |
| ovf_o | output | 32 | Sticky overflow flags; bit 31 is the cycle counter |

## Verification
Some properties are checked on every clock edge. A stopped run bit or a cleared enable freezes counter values. A pair holds still in the cycle after a chain-mode change. In a chained pair the high half only moves when the low half lands on zero. Hardware overflow flags survive any clear, sticky flags stay set until cleared, and a cycle reset empties the cycle counter. Other behaviour only shows up in the bench's scenarios. These are the exact carry and overflow placement on 64-bit wraps, the event-type filter on software increments, the odd-input pulse being dropped while chained, and the split between event-counter and cycle-counter resets. The random phase compares every register against a bench model. Its preloads sit near the wrap point so that carries and mode changes are exercised often.

// File: rtl/evc_pkg.sv
package evc_pkg;
  localparam int CNT_W   = 32;
  localparam int TYPE_W  = 16;
  localparam int ADDR_W  = 8;
  localparam int CYC_BIT = 31;

  localparam logic [TYPE_W-1:0] EVT_SWINC = 16'h0000;
  localparam logic [TYPE_W-1:0] EVT_CHAIN = 16'h001E;

  localparam logic [ADDR_W-1:0] A_CTRL      = 8'h00;
  localparam logic [ADDR_W-1:0] A_EN_SET    = 8'h01;
  localparam logic [ADDR_W-1:0] A_EN_CLR    = 8'h02;
  localparam logic [ADDR_W-1:0] A_OVF_SET   = 8'h03;
  localparam logic [ADDR_W-1:0] A_OVF_CLR   = 8'h04;
  localparam logic [ADDR_W-1:0] A_SWINC     = 8'h05;
  localparam logic [ADDR_W-1:0] A_CYC       = 8'h06;
  localparam logic [ADDR_W-1:0] A_CNT_BASE  = 8'h40;
  localparam logic [ADDR_W-1:0] A_TYPE_BASE = 8'h80;

  localparam int CTRL_RUN   = 0;
  localparam int CTRL_EVRST = 1;
  localparam int CTRL_CYRST = 2;

  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [TYPE_W-1:0] evtype_t;
endpackage

// File: rtl/evc_regs.sv
module evc_regs
  import evc_pkg::*;
#(
  parameter int N_CNT = 6
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [ADDR_W-1:0]             wr_addr_i,
  input  logic [CNT_W-1:0]              wr_data_i,
  input  logic [CNT_W-1:0]              ovf_hit_i,
  output logic                          run_o,
  output logic [CNT_W-1:0]              en_o,
  output logic [CNT_W-1:0]              ovf_o,
  output logic [N_CNT-1:0][TYPE_W-1:0]  types_o,
  output logic [N_CNT-1:0]              sw_o,
  output logic                          ev_rst_o,
  output logic                          cyc_rst_o,
  output logic [N_CNT-1:0]              cnt_we_o,
  output logic                          cyc_we_o
);
  localparam logic [CNT_W-1:0] IMPL = (CNT_W'(1) << CYC_BIT) | ((CNT_W'(1) << N_CNT) - CNT_W'(1));

  logic             run_q;
  logic [CNT_W-1:0] en_q, ovf_q;
  logic             wr_ctrl, wr_en_set, wr_en_clr, wr_ovf_set, wr_ovf_clr, wr_sw;
  logic [CNT_W-1:0] ovf_set_m, ovf_clr_m;

  assign wr_ctrl    = wr_en_i && (wr_addr_i == A_CTRL);
  assign wr_en_set  = wr_en_i && (wr_addr_i == A_EN_SET);
  assign wr_en_clr  = wr_en_i && (wr_addr_i == A_EN_CLR);
  assign wr_ovf_set = wr_en_i && (wr_addr_i == A_OVF_SET);
  assign wr_ovf_clr = wr_en_i && (wr_addr_i == A_OVF_CLR);
  assign wr_sw      = wr_en_i && (wr_addr_i == A_SWINC);

  assign ovf_set_m = wr_ovf_set ? wr_data_i : '0;
  assign ovf_clr_m = wr_ovf_clr ? wr_data_i : '0;

  assign ev_rst_o  = wr_ctrl && wr_data_i[CTRL_EVRST];
  assign cyc_rst_o = wr_ctrl && wr_data_i[CTRL_CYRST];
  assign cyc_we_o  = wr_en_i && (wr_addr_i == A_CYC);
  assign sw_o      = wr_sw ? wr_data_i[N_CNT-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      en_q  <= '0;
      ovf_q <= '0;
    end else begin
      if (wr_ctrl) run_q <= wr_data_i[CTRL_RUN];
      if (wr_en_set)      en_q <= en_q | (wr_data_i & IMPL);
      else if (wr_en_clr) en_q <= en_q & ~wr_data_i;
      // hardware set applied last: wins over a same-cycle clear
      ovf_q <= (((ovf_q | ovf_set_m) & ~ovf_clr_m) | ovf_hit_i) & IMPL;
    end
  end

  for (genvar i = 0; i < N_CNT; i++) begin : g_type
    localparam logic [ADDR_W-1:0] A_T = A_TYPE_BASE + ADDR_W'(i);
    localparam logic [ADDR_W-1:0] A_C = A_CNT_BASE + ADDR_W'(i);
    assign cnt_we_o[i] = wr_en_i && (wr_addr_i == A_C);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) types_o[i] <= '0;
      else if (wr_en_i && (wr_addr_i == A_T)) types_o[i] <= wr_data_i[TYPE_W-1:0];
    end
  end

  assign run_o = run_q;
  assign en_o  = en_q;
  assign ovf_o = ovf_q;

  assert_ovf_hw_wins_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ovf_hit_i & IMPL) != '0) |=> ((ovf_q & $past(ovf_hit_i & IMPL)) == $past(ovf_hit_i & IMPL)));

  assert_ovf_sticky_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ovf_clr |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q)));
endmodule

// File: rtl/evc_pair.sv
module evc_pair
  import evc_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  run_i,
  input  logic [1:0]            en_i,
  input  evtype_t               type_lo_i,
  input  evtype_t               type_hi_i,
  input  logic [1:0]            sw_i,
  input  logic [1:0]            evt_i,
  input  logic                  ev_rst_i,
  input  logic [1:0]            we_i,
  input  cnt_t                  wdata_i,
  output logic [1:0][CNT_W-1:0] cnt_o,
  output logic [1:0]            ovf_o
);
  logic [1:0][CNT_W-1:0] cnt_q;
  logic                  chain_q, chain_now, freeze;
  logic [1:0]            hit, inc;
  logic                  lo_max, hi_max;

  assign chain_now = en_i[1] && (type_hi_i == EVT_CHAIN);
  assign freeze    = chain_now != chain_q;

  assign hit[0] = run_i && en_i[0] && (evt_i[0] || (sw_i[0] && type_lo_i == EVT_SWINC));
  assign hit[1] = run_i && en_i[1] && (evt_i[1] || (sw_i[1] && type_hi_i == EVT_SWINC));

  assign lo_max = &cnt_q[0];
  assign hi_max = &cnt_q[1];

  // chained: odd input dropped, odd advances on even carry
  assign inc[0] = !freeze && hit[0];
  assign inc[1] = !freeze && (chain_q ? (hit[0] && lo_max) : hit[1]);

  assign ovf_o[0] = inc[0] && lo_max && !chain_q;
  assign ovf_o[1] = inc[1] && hi_max;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= 1'b0;
    else         chain_q <= chain_now;
  end

  for (genvar i = 0; i < 2; i++) begin : g_cnt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      cnt_q[i] <= '0;
      else if (ev_rst_i) cnt_q[i] <= '0;
      else if (we_i[i])  cnt_q[i] <= wdata_i;
      else if (inc[i])   cnt_q[i] <= cnt_q[i] + CNT_W'(1);
    end
  end

  assign cnt_o = cnt_q;

  assert_run_off_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !ev_rst_i && we_i == 2'b00) |=> $stable(cnt_q));

  assert_disabled_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i[0] && !ev_rst_i && !we_i[0]) |=> $stable(cnt_q[0]));

  assert_mode_change_pause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze && !ev_rst_i && we_i == 2'b00) |=> $stable(cnt_q));

  assert_hi_moves_on_carry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chain_q && !freeze && !ev_rst_i && we_i == 2'b00) |=> ($stable(cnt_q[1]) || cnt_q[0] == '0));
endmodule

// File: rtl/evc_cycle.sv
module evc_cycle
  import evc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic en_i,
  input  logic clr_i,
  input  logic we_i,
  input  cnt_t wdata_i,
  output cnt_t cnt_o,
  output logic ovf_o
);
  cnt_t cnt_q;
  logic inc;

  assign inc   = run_i && en_i;
  assign ovf_o = inc && (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (we_i)  cnt_q <= wdata_i;
    else if (inc)   cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;

  assert_cyc_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/evc_bank.sv
module evc_bank
  import evc_pkg::*;
#(
  parameter int N_CNT = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [7:0]        wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic [7:0]        rd_addr_i,
  output logic [31:0]       rd_data_o,
  input  logic [N_CNT-1:0]  evt_i,
  output logic [31:0]       ovf_o
);
  localparam int N_PAIR = N_CNT / 2;
  localparam int GAP_W  = CYC_BIT - N_CNT;

  logic                         run;
  logic [CNT_W-1:0]             en, ovf_st, ovf_hit;
  logic [N_CNT-1:0][TYPE_W-1:0] types;
  logic [N_CNT-1:0]             sw, cnt_we, ev_hit;
  logic                         ev_rst, cyc_rst, cyc_we, cyc_hit;
  logic [N_CNT-1:0][CNT_W-1:0]  cnt_all;
  cnt_t                         cyc_cnt;

  evc_regs #(.N_CNT(N_CNT)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .ovf_hit_i (ovf_hit),
    .run_o     (run),
    .en_o      (en),
    .ovf_o     (ovf_st),
    .types_o   (types),
    .sw_o      (sw),
    .ev_rst_o  (ev_rst),
    .cyc_rst_o (cyc_rst),
    .cnt_we_o  (cnt_we),
    .cyc_we_o  (cyc_we)
  );

  for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
    evc_pair u_pair (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (run),
      .en_i      (en[2*p +: 2]),
      .type_lo_i (types[2*p]),
      .type_hi_i (types[2*p+1]),
      .sw_i      (sw[2*p +: 2]),
      .evt_i     (evt_i[2*p +: 2]),
      .ev_rst_i  (ev_rst),
      .we_i      (cnt_we[2*p +: 2]),
      .wdata_i   (wr_data_i),
      .cnt_o     (cnt_all[2*p +: 2]),
      .ovf_o     (ev_hit[2*p +: 2])
    );
  end

  evc_cycle u_cycle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .en_i    (en[CYC_BIT]),
    .clr_i   (cyc_rst),
    .we_i    (cyc_we),
    .wdata_i (wr_data_i),
    .cnt_o   (cyc_cnt),
    .ovf_o   (cyc_hit)
  );

  assign ovf_hit = {cyc_hit, {GAP_W{1'b0}}, ev_hit};

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == A_CTRL)                                rd_data_o = {31'b0, run};
    else if (rd_addr_i == A_EN_SET || rd_addr_i == A_EN_CLR)   rd_data_o = en;
    else if (rd_addr_i == A_OVF_SET || rd_addr_i == A_OVF_CLR) rd_data_o = ovf_st;
    else if (rd_addr_i == A_CYC)                            rd_data_o = cyc_cnt;
    for (int i = 0; i < N_CNT; i++) begin
      if (rd_addr_i == A_CNT_BASE + ADDR_W'(i))  rd_data_o = cnt_all[i];
      if (rd_addr_i == A_TYPE_BASE + ADDR_W'(i)) rd_data_o = {{(CNT_W-TYPE_W){1'b0}}, types[i]};
    end
  end

  assign ovf_o = ovf_st;
endmodule

// File: tb/evc_bank_tb_top.sv
`timescale 1ns/1ps
module evc_bank_tb_top;
  localparam int N = 6;
  localparam logic [31:0] IMPL = 32'h8000_0000 | ((32'h1 << N) - 32'h1);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [N-1:0] evt = '0;
  logic [31:0] ovf;

  int n_chk = 0;
  int n_bad = 0;

  bit          m_run;
  logic [31:0] m_en, m_ovf, m_cyc;
  logic [31:0] m_cnt [N];
  logic [15:0] m_typ [N];
  bit          m_ch  [N/2];

  always #2.5 clk = ~clk;

  evc_bank #(.N_CNT(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .evt_i(evt), .ovf_o(ovf)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    if (a == 8'h00) return {31'b0, m_run};
    if (a == 8'h01 || a == 8'h02) return m_en;
    if (a == 8'h03 || a == 8'h04) return m_ovf;
    if (a == 8'h06) return m_cyc;
    if (a >= 8'h40 && a < 8'h40 + N) return m_cnt[a - 8'h40];
    if (a >= 8'h80 && a < 8'h80 + N) return {16'b0, m_typ[a - 8'h80]};
    return 32'h0;
  endfunction

  task automatic model_step(bit we, logic [7:0] a, logic [31:0] d, logic [N-1:0] ev);
    logic [31:0] hw = '0;
    logic [31:0] sw = (we && a == 8'h05) ? d : 32'h0;
    logic [31:0] n_cnt [N];
    logic [31:0] n_cyc = m_cyc;
    for (int i = 0; i < N; i++) n_cnt[i] = m_cnt[i];
    for (int p = 0; p < N/2; p++) begin
      int lo = 2*p;
      int hi = 2*p + 1;
      bit now = m_en[hi] && m_typ[hi] == 16'h001E;
      bit h_lo = m_run && m_en[lo] && (ev[lo] || (sw[lo] && m_typ[lo] == 16'h0));
      bit h_hi = m_run && m_en[hi] && (ev[hi] || (sw[hi] && m_typ[hi] == 16'h0));
      if (now == m_ch[p]) begin
        if (m_ch[p]) begin
          if (h_lo) begin
            n_cnt[lo] = m_cnt[lo] + 1;
            if (m_cnt[lo] == 32'hFFFF_FFFF) begin
              n_cnt[hi] = m_cnt[hi] + 1;
              if (m_cnt[hi] == 32'hFFFF_FFFF) hw[hi] = 1'b1;
            end
          end
        end else begin
          if (h_lo) begin n_cnt[lo] = m_cnt[lo] + 1; if (m_cnt[lo] == 32'hFFFF_FFFF) hw[lo] = 1'b1; end
          if (h_hi) begin n_cnt[hi] = m_cnt[hi] + 1; if (m_cnt[hi] == 32'hFFFF_FFFF) hw[hi] = 1'b1; end
        end
      end
      m_ch[p] = now;
    end
    if (m_run && m_en[31]) begin
      n_cyc = m_cyc + 1;
      if (m_cyc == 32'hFFFF_FFFF) hw[31] = 1'b1;
    end
    m_ovf = ((m_ovf | ((we && a == 8'h03) ? d : 32'h0)) & ~((we && a == 8'h04) ? d : 32'h0) | hw) & IMPL;
    if (we) begin
      if (a == 8'h00) begin
        m_run = d[0];
        if (d[1]) for (int i = 0; i < N; i++) n_cnt[i] = 32'h0;
        if (d[2]) n_cyc = 32'h0;
      end
      if (a == 8'h01) m_en = m_en | (d & IMPL);
      if (a == 8'h02) m_en = m_en & ~d;
      if (a == 8'h06) n_cyc = d;
      if (a >= 8'h40 && a < 8'h40 + N) n_cnt[a - 8'h40] = d;
      if (a >= 8'h80 && a < 8'h80 + N) m_typ[a - 8'h80] = d[15:0];
    end
    for (int i = 0; i < N; i++) m_cnt[i] = n_cnt[i];
    m_cyc = n_cyc;
  endtask

  function automatic logic [7:0] pick_addr();
    int r = $urandom_range(0, 3);
    if (r == 0) return 8'($urandom_range(0, 7));
    if (r == 1 || r == 2) return 8'h40 + 8'($urandom_range(0, N));
    return 8'h80 + 8'($urandom_range(0, N - 1));
  endfunction

  // one clock: compare against model, drive, advance
  task automatic step(bit we, logic [7:0] a, logic [31:0] d, logic [N-1:0] ev);
    chk("MODEL ovf_o", ovf, m_ovf);
    rd_addr = pick_addr();
    #0.1;
    chk("MODEL read", rd_data, exp_rd(rd_addr));
    wr_en = we; wr_addr = a; wr_data = d; evt = ev;
    model_step(we, a, d, ev);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; evt = '0;
  endtask

  task automatic op(logic [7:0] a, logic [31:0] d);
    step(1'b1, a, d, '0);
  endtask

  task automatic idle(logic [N-1:0] ev);
    step(1'b0, 8'h0, 32'h0, ev);
  endtask

  task automatic dchk(string tag, logic [7:0] a, logic [31:0] exp);
    rd_addr = a;
    #0.1;
    chk(tag, rd_data, exp);
  endtask

  initial begin
    #500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] c0;
    void'($urandom(32'd20240611));
    m_run = 0; m_en = 0; m_ovf = 0; m_cyc = 0;
    for (int i = 0; i < N; i++) begin m_cnt[i] = 0; m_typ[i] = 0; end
    for (int p = 0; p < N/2; p++) m_ch[p] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    dchk("R1 ctrl", 8'h00, 32'h0);
    dchk("R1 enable", 8'h01, 32'h0);
    dchk("R1 cnt0", 8'h40, 32'h0);
    dchk("R1 type0", 8'h80, 32'h0);
    chk("R1 ovf_o", ovf, 32'h0);

    op(8'h01, 32'h8000_003F);
    // R2 run bit clear
    op(8'h05, 32'h1);
    dchk("R2 swinc ignored", 8'h40, 32'h0);
    idle(6'h01);
    dchk("R2 pulse ignored", 8'h40, 32'h0);
    dchk("R2 cycle stopped", 8'h06, 32'h0);

    op(8'h00, 32'h1);
    // R3 enable mask
    op(8'h02, 32'h2);
    op(8'h05, 32'h3);
    dchk("R3 enabled advances", 8'h40, 32'h1);
    dchk("R3 disabled holds", 8'h41, 32'h0);
    // R4 type filter
    op(8'h82, 32'h11);
    op(8'h05, 32'h5);
    dchk("R4 wrong type holds", 8'h42, 32'h0);
    dchk("R4 swinc type advances", 8'h40, 32'h2);
    // R5 wrap unchained
    op(8'h40, 32'hFFFF_FFFF);
    op(8'h05, 32'h1);
    dchk("R5 wrap", 8'h40, 32'h0);
    chk("R5 ovf bit0", {31'b0, ovf[0]}, 32'h1);
    op(8'h04, 32'h1);
    chk("R13 clear", {31'b0, ovf[0]}, 32'h0);
    // R6 chain
    op(8'h81, 32'h1E);
    op(8'h01, 32'h2);
    op(8'h40, 32'hFFFF_FFFF);
    op(8'h41, 32'h5);
    op(8'h05, 32'h1);
    dchk("R6 low wraps", 8'h40, 32'h0);
    dchk("R6 high carries", 8'h41, 32'h6);
    chk("R7 no ovf", {30'b0, ovf[1:0]}, 32'h0);
    // R7 high wrap
    op(8'h40, 32'hFFFF_FFFF);
    op(8'h41, 32'hFFFF_FFFF);
    op(8'h05, 32'h1);
    dchk("R7 high wrap", 8'h41, 32'h0);
    chk("R7 ovf odd only", {30'b0, ovf[1:0]}, 32'h2);
    op(8'h04, 32'h2);
    // R8 pause on unchain
    op(8'h40, 32'd10);
    op(8'h02, 32'h2);
    idle(6'h01);
    dchk("R8 paused", 8'h40, 32'd10);
    idle(6'h01);
    dchk("R8 resumes", 8'h40, 32'd11);
    // R9 hardware pulses
    op(8'h01, 32'h2);
    idle('0);
    op(8'h40, 32'hFFFF_FFFF);
    op(8'h41, 32'h0);
    idle(6'h03);
    dchk("R9 chained low", 8'h40, 32'h0);
    dchk("R9 odd pulse dropped", 8'h41, 32'h1);
    idle(6'h04);
    dchk("R9 unchained pulse", 8'h42, 32'h1);
    // R10 event reset spares cycle counter
    op(8'h00, 32'h0);
    dchk("R10 cycle nonzero", 8'h06, m_cyc);
    c0 = m_cyc;
    op(8'h00, 32'h2);
    dchk("R10 cnt1 cleared", 8'h41, 32'h0);
    dchk("R10 cnt2 cleared", 8'h42, 32'h0);
    dchk("R10 cycle kept", 8'h06, c0);
    // R11 cycle counter
    op(8'h00, 32'h4);
    dchk("R11 cycle cleared", 8'h06, 32'h0);
    op(8'h00, 32'h1);
    op(8'h06, 32'hFFFF_FFFE);
    idle('0);
    idle('0);
    dchk("R11 cycle wrapped", 8'h06, 32'h0);
    chk("R11 ovf bit31", {31'b0, ovf[31]}, 32'h1);
    op(8'h04, 32'h8000_0000);
    // R12 unimplemented bits
    op(8'h05, 32'hFFFF_FFC0);
    dchk("R12 cnt0 untouched", 8'h40, 32'h0);
    dchk("R12 cnt3 untouched", 8'h43, 32'h0);
    op(8'h01, 32'h7FFF_FFC0);
    dchk("R12 enable gap", 8'h01, 32'h8000_003F);
    op(8'h03, 32'h7FFF_FFC0);
    dchk("R12 ovf gap", 8'h03, 32'h0);
    // R13 priority and stickiness
    op(8'h42, 32'hFFFF_FFFF);
    step(1'b1, 8'h04, 32'h4, 6'h04);
    chk("R13 hw beats clear", {31'b0, ovf[2]}, 32'h1);
    idle('0);
    chk("R13 sticky", {31'b0, ovf[2]}, 32'h1);
    op(8'h04, 32'h4);
    chk("R13 cleared", {31'b0, ovf[2]}, 32'h0);
    op(8'h03, 32'h4);
    chk("R13 software set", {31'b0, ovf[2]}, 32'h1);
    op(8'h04, 32'h4);
    // R14 write and reset priority
    step(1'b1, 8'h43, 32'h55, 6'h08);
    dchk("R14 write beats inc", 8'h43, 32'h55);
    step(1'b1, 8'h00, 32'h3, 6'h3F);
    dchk("R14 reset beats inc", 8'h43, 32'h0);

    // random phase against model
    for (int k = 0; k < 4000; k++) begin
      int r = $urandom_range(0, 99);
      logic [N-1:0] ev = N'($urandom & $urandom & $urandom);
      logic [7:0] idx = 8'($urandom_range(0, N - 1));
      if (r < 25)      step(1'b0, 8'h0, 32'h0, ev);
      else if (r < 45) step(1'b1, 8'h05, $urandom, ev);
      else if (r < 55) step(1'b1, 8'h40 + idx,
                            ($urandom_range(0, 3) != 0) ? 32'hFFFF_FFFF - $urandom_range(0, 3) : 32'($urandom_range(0, 9)), ev);
      else if (r < 63) begin
        int t = $urandom_range(0, 2);
        step(1'b1, 8'h80 + idx, (t == 0) ? 32'h0 : (t == 1) ? 32'h1E : 32'h11, ev);
      end
      else if (r < 73) step(1'b1, 8'h01, $urandom, ev);
      else if (r < 80) step(1'b1, 8'h02, $urandom & $urandom, ev);
      else if (r < 85) step(1'b1, 8'h04, $urandom, ev);
      else if (r < 88) step(1'b1, 8'h03, $urandom & $urandom, ev);
      else if (r < 92) step(1'b1, 8'h00,
                            {29'b0, ($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0), ($urandom_range(0, 9) != 0)}, ev);
      else if (r < 96) step(1'b1, 8'h06, 32'hFFFF_FFF0 + $urandom_range(0, 15), ev);
      else             step(1'b0, 8'h0, 32'h0, ev);
    end
    idle('0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule